// File: doc/BRIEF.md
# Bidirectional Latched/Registered Bus Transceiver

This block couples two 18-bit ports, A and B, with one independent data path in each direction. Each path has a single storage element whose mode is chosen at run time by its control inputs. With the latch enable high, the path is transparent and the far port follows the near port within the same cycle. With the latch enable low, the path holds its stored word. In that state a rising edge on the path's capture clock loads a new word, provided the active-low capture enable is asserted. Each path also has its own active-low output enable. That enable decides whether the far port drives its word onto the shared bus.

The capture clocks are ordinary data inputs. They are sampled by the system clock, and a low-to-high change between two system clock edges counts as one capture edge. Each port is presented as an input vector, an output vector and one drive flag, so the core stays free of tri-states. The surrounding logic, or a testbench, merges these into a bus. When both directions would drive at once, a contention flag is raised.

Top module: `ubx_transceiver`

## Requirements
- R1: While `leAb` is 1, `bOut` equals `aIn` in the same cycle with no clock edge needed. While `leBa` is 1, `aOut` equals `bIn` in the same way.
- R2: While `leAb` is 0 and no capture edge is accepted, `bOut` keeps its value from one cycle to the next, whatever `aIn` does. This includes `clkAb` held steady at 1 or at 0.
- R3: While `leAb` is 0 and `ceAbN` is 0, a system clock edge that sees `clkAb` at 1 after a cycle with `clkAb` at 0 stores `aIn`. From the next cycle on, `bOut` shows that value.
- R4: While `ceAbN` is 1, a low-to-high change of `clkAb` stores nothing, and `bOut` keeps its value.
- R5: While `leAb` is 1, each system clock edge copies `aIn` into storage. After `leAb` falls, `bOut` keeps the `aIn` value that was present at the last edge with `leAb` at 1.
- R6: `bOe` equals the inverse of `oeAbN`, and `aOe` equals the inverse of `oeBaN`, in the same cycle. The two are independent of each other and of the data.
- R7: The B-to-A path behaves as R1 to R5 describe, using `bIn`, `aOut`, `leBa`, `clkBa` and `ceBaN`.
- R8: While `rstN` is 0, both storage elements clear to zero. Each capture-clock history is set to 1, so a capture clock held at 1 through reset does not count as an edge afterwards.
- R9: `contention` is 1 exactly when `aOe` and `bOe` are both 1.
- R10: An output enable has no effect on storage. A word captured while a port's drive flag is 0 appears on that port once the flag returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| aIn | input | 18 | Word received from bus A |
| aOut | output | 18 | Word offered to bus A by the B-to-A path |
| aOe | output | 1 | Drive flag for bus A |
| bIn | input | 18 | Word received from bus B |
| bOut | output | 18 | Word offered to bus B by the A-to-B path |
| bOe | output | 1 | Drive flag for bus B |
| leAb | input | 1 | A-to-B latch enable, 1 = transparent |
| clkAb | input | 1 | A-to-B capture clock |
| ceAbN | input | 1 | A-to-B capture enable, active low |
| oeAbN | input | 1 | A-to-B output enable, active low |
| leBa | input | 1 | B-to-A latch enable, 1 = transparent |
| clkBa | input | 1 | B-to-A capture clock |
| ceBaN | input | 1 | B-to-A capture enable, active low |
| oeBaN | input | 1 | B-to-A output enable, active low |
| contention | output | 1 | Both ports flagged to drive at once |

## Verification
The assertions check the rules that hold on every cycle. These are: transparency whenever a latch enable is high; stability of a closed path when its capture clock is low or its capture enable is off; loading on an accepted capture edge; drive flags and contention following the enables; and zero contents in the first cycle after reset. Some behaviours need an ordered scenario, and only the bench shows them. One is the value kept when a latch closes. Another is a capture clock held at 1 through reset producing no edge. A third is a word captured while the port is released showing up once it drives again. The bench also exercises both directions together.

// File: rtl/ubx_pkg.sv
package ubx_pkg;

  // Strobes handed from one direction's control to its datapath
  typedef struct packed {
    logic pass;   // transparent: output follows input
    logic load;   // write the storage element this cycle
    logic drive;  // far port drives the bus
  } dirStrobe_t;

  localparam int unsigned NUM_DIRS = 2;
  localparam int unsigned DIR_AB   = 0;
  localparam int unsigned DIR_BA   = 1;

endpackage

// File: rtl/ubx_ctrl.sv
module ubx_ctrl
  import ubx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       latchEn,
  input  logic       capClk,
  input  logic       capEnN,
  input  logic       outEnN,
  output dirStrobe_t strobe
);

  // Last sampled level of the capture clock; reset high so a clock
  // held high through reset is not mistaken for a new edge.
  logic prevCapClk;
  logic capEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevCapClk <= 1'b1;
    else       prevCapClk <= capClk;
  end

  assign capEdge = capClk & ~prevCapClk;

  always_comb begin
    strobe.pass  = latchEn;
    // transparent mode keeps storage tracking; otherwise a qualified edge
    strobe.load  = latchEn | (~capEnN & capEdge);
    strobe.drive = ~outEnN;
  end

endmodule

// File: rtl/ubx_path.sv
module ubx_path
  import ubx_pkg::*;
#(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rstN,
  input  dirStrobe_t   strobe,
  input  logic [W-1:0] dIn,
  output logic [W-1:0] dOut,
  output logic         dEn
);

  logic [W-1:0] held;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            held <= '0;
    else if (strobe.load) held <= dIn;
  end

  assign dOut = strobe.pass ? dIn : held;
  assign dEn  = strobe.drive;

endmodule

// File: rtl/ubx_transceiver.sv
module ubx_transceiver
  import ubx_pkg::*;
#(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] aIn,
  output logic [W-1:0] aOut,
  output logic         aOe,
  input  logic [W-1:0] bIn,
  output logic [W-1:0] bOut,
  output logic         bOe,
  input  logic         leAb,
  input  logic         clkAb,
  input  logic         ceAbN,
  input  logic         oeAbN,
  input  logic         leBa,
  input  logic         clkBa,
  input  logic         ceBaN,
  input  logic         oeBaN,
  output logic         contention
);

  logic [NUM_DIRS-1:0]         dirLe, dirClk, dirCeN, dirOeN, dirEn;
  logic [NUM_DIRS-1:0][W-1:0]  dirIn, dirOut;
  dirStrobe_t [NUM_DIRS-1:0]   dirStrobe;

  assign dirLe [DIR_AB] = leAb;   assign dirLe [DIR_BA] = leBa;
  assign dirClk[DIR_AB] = clkAb;  assign dirClk[DIR_BA] = clkBa;
  assign dirCeN[DIR_AB] = ceAbN;  assign dirCeN[DIR_BA] = ceBaN;
  assign dirOeN[DIR_AB] = oeAbN;  assign dirOeN[DIR_BA] = oeBaN;
  assign dirIn [DIR_AB] = aIn;    assign dirIn [DIR_BA] = bIn;

  for (genvar d = 0; d < NUM_DIRS; d++) begin : g_dir
    ubx_ctrl u_ctrl (
      .clk     (clk),
      .rstN    (rstN),
      .latchEn (dirLe[d]),
      .capClk  (dirClk[d]),
      .capEnN  (dirCeN[d]),
      .outEnN  (dirOeN[d]),
      .strobe  (dirStrobe[d])
    );
    ubx_path #(.W(W)) u_path (
      .clk    (clk),
      .rstN   (rstN),
      .strobe (dirStrobe[d]),
      .dIn    (dirIn[d]),
      .dOut   (dirOut[d]),
      .dEn    (dirEn[d])
    );
  end

  assign bOut = dirOut[DIR_AB];
  assign bOe  = dirEn[DIR_AB];
  assign aOut = dirOut[DIR_BA];
  assign aOe  = dirEn[DIR_BA];

  assign contention = &dirEn;

endmodule

// File: rtl/ubx_checker.sv
module ubx_checker #(
  parameter int unsigned W = 18
) (
  input logic         clk,
  input logic         rstN,
  input logic [W-1:0] aIn,
  input logic [W-1:0] aOut,
  input logic         aOe,
  input logic [W-1:0] bIn,
  input logic [W-1:0] bOut,
  input logic         bOe,
  input logic         leAb,
  input logic         clkAb,
  input logic         ceAbN,
  input logic         oeAbN,
  input logic         leBa,
  input logic         clkBa,
  input logic         ceBaN,
  input logic         oeBaN,
  input logic         contention
);

  p_transparent_r1: assert property (@(posedge clk) disable iff (!rstN)
    leAb |-> (bOut == aIn));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!leAb && !clkAb) |=> (leAb || $stable(bOut)));

  p_capture_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!leAb && !ceAbN && clkAb && !$past(clkAb) && $past(rstN))
      |=> (leAb || bOut == $past(aIn)));

  p_gated_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!leAb && ceAbN) |=> (leAb || $stable(bOut)));

  p_drive_r6: assert property (@(posedge clk) disable iff (!rstN)
    (bOe == !oeAbN) && (aOe == !oeBaN));

  p_transparent_r7: assert property (@(posedge clk) disable iff (!rstN)
    leBa |-> (aOut == bIn));

  p_gated_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!leBa && (ceBaN || !clkBa)) |=> (leBa || $stable(aOut)));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(rstN) && !leAb && !leBa) |-> (aOut == '0 && bOut == '0));

  p_contention_r9: assert property (@(posedge clk) disable iff (!rstN)
    contention == (aOe && bOe));

endmodule

bind ubx_transceiver ubx_checker #(.W(W)) u_chk (
  .clk(clk), .rstN(rstN), .aIn(aIn), .aOut(aOut), .aOe(aOe),
  .bIn(bIn), .bOut(bOut), .bOe(bOe), .leAb(leAb), .clkAb(clkAb),
  .ceAbN(ceAbN), .oeAbN(oeAbN), .leBa(leBa), .clkBa(clkBa),
  .ceBaN(ceBaN), .oeBaN(oeBaN), .contention(contention)
);

// File: tb/sim_ubx_transceiver.sv
`timescale 1ns/100ps
module sim_ubx_transceiver;

  localparam int W = 18;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] aIn = '0, bIn = '0;
  logic [W-1:0] aOut, bOut;
  logic         aOe, bOe, contention;
  logic leAb = 0, clkAb = 1, ceAbN = 1, oeAbN = 1;
  logic leBa = 0, clkBa = 1, ceBaN = 1, oeBaN = 1;

  ubx_transceiver #(.W(W)) u0 (
    .clk(clk), .rstN(rstN), .aIn(aIn), .aOut(aOut), .aOe(aOe),
    .bIn(bIn), .bOut(bOut), .bOe(bOe), .leAb(leAb), .clkAb(clkAb),
    .ceAbN(ceAbN), .oeAbN(oeAbN), .leBa(leBa), .clkBa(clkBa),
    .ceBaN(ceBaN), .oeBaN(oeBaN), .contention(contention)
  );

  always #2 clk = ~clk;

  // shared buses resolved from each port's drive flag
  wire [W-1:0] busA = aOe ? aOut : 'z;
  wire [W-1:0] busB = bOe ? bOut : 'z;

  typedef enum int {SEL_BOUT, SEL_AOUT, SEL_BOE, SEL_AOE, SEL_CONT, SEL_BUSB} sel_e;
  typedef struct {
    sel_e         sel;
    logic [W-1:0] val;
    string        req;
  } item_t;

  item_t queueExp[$];
  event  sampleEv;
  int    applied = 0;
  int    misses  = 0;
  bit    done    = 0;

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      @(sampleEv);
      while (queueExp.size() > 0) begin
        item_t it;
        logic [W-1:0] act;
        it = queueExp.pop_front();
        case (it.sel)
          SEL_BOUT: act = bOut;
          SEL_AOUT: act = aOut;
          SEL_BOE:  act = {{(W-1){1'b0}}, bOe};
          SEL_AOE:  act = {{(W-1){1'b0}}, aOe};
          SEL_CONT: act = {{(W-1){1'b0}}, contention};
          default:  act = busB;
        endcase
        applied++;
        if (act !== it.val) begin
          misses++;
          $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.val);
        end
      end
    end
  end

  task automatic expect_(sel_e s, logic [W-1:0] v, string r);
    item_t it;
    it.sel = s; it.val = v; it.req = r;
    queueExp.push_back(it);
  endtask

  // settle combinational paths, then hand the batch to the monitor
  task automatic flush();
    #1;
    ->sampleEv;
    #0.5;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      misses++;
      applied++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", applied, misses);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    // R8: storage cleared during reset
    expect_(SEL_BOUT, '0, "R8"); expect_(SEL_AOUT, '0, "R8");
    flush();
    rstN = 1'b1;
    step();
    // clkAb held at 1 through reset, capture enable now on: no edge (R8)
    ceAbN = 0; aIn = 18'h2_5A5A;
    step();
    expect_(SEL_BOUT, '0, "R8"); expect_(SEL_BOE, '0, "R6");
    expect_(SEL_CONT, '0, "R9");
    flush();

    // R6: output enable drives the flag of the far port only
    oeAbN = 0;
    expect_(SEL_BOE, 1, "R6"); expect_(SEL_AOE, 0, "R6");
    flush();

    // R1: transparent
    ceAbN = 1; leAb = 1; aIn = 18'h2_A5A5;
    expect_(SEL_BOUT, 18'h2_A5A5, "R1"); expect_(SEL_BUSB, 18'h2_A5A5, "R1");
    flush();
    aIn = 18'h0_1234;
    expect_(SEL_BOUT, 18'h0_1234, "R1");
    flush();
    step();

    // R5: close latch, last value at an edge with leAb high is kept
    leAb = 0; aIn = 18'h3_FFFF;
    expect_(SEL_BOUT, 18'h0_1234, "R5");
    flush();
    step();
    expect_(SEL_BOUT, 18'h0_1234, "R2");
    flush();

    // R3: rising edge with capture enabled
    clkAb = 0; ceAbN = 0;
    step();
    clkAb = 1; aIn = 18'h0_F0F0;
    expect_(SEL_BOUT, 18'h0_1234, "R3");
    flush();
    step();
    expect_(SEL_BOUT, 18'h0_F0F0, "R3");
    flush();

    // R2: clock held high, new data ignored
    aIn = 18'h1_1111;
    step(); step();
    expect_(SEL_BOUT, 18'h0_F0F0, "R2");
    flush();

    // R4: edge while capture disabled
    ceAbN = 1; clkAb = 0;
    step();
    clkAb = 1; aIn = 18'h2_2222;
    step(); step();
    expect_(SEL_BOUT, 18'h0_F0F0, "R4");
    flush();

    // R10: capture while released, then re-enable
    oeAbN = 1; ceAbN = 0; clkAb = 0;
    step();
    clkAb = 1; aIn = 18'h3_3333;
    step();
    expect_(SEL_BOE, 0, "R10");
    flush();
    oeAbN = 0;
    expect_(SEL_BOE, 1, "R10"); expect_(SEL_BOUT, 18'h3_3333, "R10");
    flush();

    // R7: B-to-A transparent, contention with both driving (R9)
    leBa = 1; bIn = 18'h1_5555; oeBaN = 0;
    expect_(SEL_AOUT, 18'h1_5555, "R7"); expect_(SEL_AOE, 1, "R6");
    expect_(SEL_CONT, 1, "R9");
    flush();
    step();
    // R7: B-to-A closes and holds, then captures on an edge
    leBa = 0; bIn = 18'h0_0007;
    expect_(SEL_AOUT, 18'h1_5555, "R7");
    flush();
    clkBa = 0; ceBaN = 0;
    step();
    clkBa = 1; bIn = 18'h2_AAAA;
    step();
    expect_(SEL_AOUT, 18'h2_AAAA, "R7");
    expect_(SEL_BOUT, 18'h3_3333, "R7");
    flush();

    // R9: release A-to-B, contention clears
    oeAbN = 1;
    expect_(SEL_CONT, 0, "R9"); expect_(SEL_AOE, 1, "R9");
    flush();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, misses);
    $finish;
  end

endmodule